// File: doc/BRIEF.md
# State-Change Serial Reporter

This block sits beside a larger controller and watches its 5-bit state code. Whenever the code differs from the value it last reported, it sends one asynchronous serial byte to a host, so that software on the other end can follow the controller's state. The byte is the state code zero-extended to eight bits. Each frame is a low start bit, eight data bits sent least significant bit first, an even-parity bit and a high stop bit.

A free-running baud counter produces one tick per bit period. All decisions in the transmitter are made on that tick. The last reported value is refreshed only on a tick while the transmitter is idle. Changes that occur while a frame is on the line are therefore not queued: when the line becomes free, only the value present at that moment is sent. The transmitter machine has two states. `TX_IDLE` goes to `TX_SEND` on a tick when a request is pending, and loads the frame at that moment. `TX_SEND` shifts one bit per tick and returns to `TX_IDLE` on the tick that ends the stop bit.

Top module: `state_uart_reporter`

## Requirements
- R1: While the transmitter is idle, and during reset, `tx_o` is high and `busy_o` is low.
- R2: A frame starts on a baud tick in the idle state when `state_i` differs from the last reported value. No frame starts while they are equal. Reset sets the last reported value to 0, so a state of 0 right after reset sends nothing.
- R3: Frame layout on `tx_o`, in time order: one start bit of 0, then data bits d0 through d7 where the data byte is {3'b000, state}, then a parity bit equal to d0^d1^…^d7, then one stop bit of 1.
- R4: Each bit occupies exactly CLKS_PER_BIT clock cycles. The baud counter runs from 0 to CLKS_PER_BIT-1 and wraps. The default of 5208 gives about 9600 baud from a 50 MHz clock.
- R5: `busy_o` rises on the clock edge that loads a frame, which is the same edge on which the start bit appears. It falls after the stop bit has been on the line for one full bit period, so it stays high for 11 × CLKS_PER_BIT cycles.
- R6: The last reported value changes only on a baud tick while not busy. If the state changes several times during a frame, the next frame carries only the value present when the transmitter is idle again. Intermediate values are never sent.
- R7: If the state changes during a frame and returns to the value being sent before the frame ends, no further frame is sent.
- R8: A synchronous reset asserted during a frame aborts it: `tx_o` is high and `busy_o` is low after the first reset edge. After release, a nonzero state is reported again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| state_i | input | STATE_W (5) | State code being monitored |
| tx_o | output | 1 | Serial transmit line, idles high |
| busy_o | output | 1 | High while a frame is in flight |

## Verification
The bench decodes frames at mid-bit and checks the payload, parity, stop bit and the exact busy length for several state codes. A design with a wrong divider would report the wrong busy length. A design that swaps the bit order or sends the wrong parity would report a wrong byte or parity value. Two more cases change the state while a frame is in flight: once through two values, and once away from and back to the value being sent. A design that queued changes, or refreshed the last reported value while busy, would send an intermediate value or an extra frame. Reset is also applied in mid-frame. A design that failed to clear the last reported value would then stay silent after release.

// File: rtl/sur_pkg.sv
package sur_pkg;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // start + data + parity + stop
    function automatic int frame_len(input int data_w);
        return data_w + 3;
    endfunction

endpackage

// File: rtl/sur_baud_gen.sv
module sur_baud_gen #(
    parameter int CLKS_PER_BIT = 5208
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/sur_change_track.sv
module sur_change_track #(
    parameter int STATE_W = 5,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               busy,
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] last_q,
    output logic               req,
    output logic [DATA_W-1:0]  payload
);
    localparam int PAD_W = DATA_W - STATE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
        end else if (tick && !busy) begin
            last_q <= state_i;
        end
    end

    assign req     = (state_i != last_q);
    assign payload = {{PAD_W{1'b0}}, state_i};

endmodule

// File: rtl/sur_tx_fsm.sv
module sur_tx_fsm
    import sur_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              req,
    input  logic [DATA_W-1:0] payload,
    output logic              tx,
    output logic              busy
);
    localparam int FRAME_W = frame_len(DATA_W);
    localparam int BCW     = $clog2(FRAME_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_W - 1);

    tx_state_e     st_q, st_d;
    logic [FRAME_W-1:0] shreg_q;
    logic [BCW-1:0]     bitcnt_q;
    logic load, shift, done;

    assign done = (bitcnt_q == LAST_BIT);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= TX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and datapath controls
    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        shift = 1'b0;
        unique case (st_q)
            TX_IDLE: begin
                if (tick && req) begin
                    load = 1'b1;
                    st_d = TX_SEND;
                end
            end
            TX_SEND: begin
                if (tick) begin
                    if (done) begin
                        st_d = TX_IDLE;
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            default: st_d = TX_IDLE;
        endcase
    end

    // frame shifter and bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q  <= '1;
            bitcnt_q <= '0;
        end else if (load) begin
            shreg_q  <= {1'b1, ^payload, payload, 1'b0};
            bitcnt_q <= '0;
        end else if (shift) begin
            shreg_q  <= {1'b1, shreg_q[FRAME_W-1:1]};
            bitcnt_q <= bitcnt_q + 1'b1;
        end else if (st_q == TX_SEND && tick && done) begin
            bitcnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            TX_SEND: begin
                tx   = shreg_q[0];
                busy = 1'b1;
            end
            default: begin
                tx   = 1'b1;
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/state_uart_reporter.sv
module state_uart_reporter #(
    parameter int CLKS_PER_BIT = 5208,
    parameter int STATE_W      = 5,
    parameter int DATA_W       = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] state_i,
    output logic               tx_o,
    output logic               busy_o
);
    logic               baud_tick;
    logic               send_req;
    logic [STATE_W-1:0] last_rep;
    logic [DATA_W-1:0]  tx_byte;

    sur_baud_gen #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_baud (
        .clk (clk),
        .rst (rst),
        .tick(baud_tick)
    );

    sur_change_track #(
        .STATE_W(STATE_W),
        .DATA_W (DATA_W)
    ) u_track (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick),
        .busy   (busy_o),
        .state_i(state_i),
        .last_q (last_rep),
        .req    (send_req),
        .payload(tx_byte)
    );

    sur_tx_fsm #(
        .DATA_W(DATA_W)
    ) u_tx (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick),
        .req    (send_req),
        .payload(tx_byte),
        .tx     (tx_o),
        .busy   (busy_o)
    );

endmodule

// File: rtl/state_uart_reporter_chk.sv
module state_uart_reporter_chk #(
    parameter int STATE_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [STATE_W-1:0] state_i,
    input logic               tx,
    input logic               busy,
    input logic               tick,
    input logic [STATE_W-1:0] last_q
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx);

    p_stop_high_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> $past(tx));

    p_bit_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(tx)) |-> $past(tick));

    p_load_on_diff_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && tick && (state_i != last_q)) |=> busy);

    p_no_load_same_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && tick && (state_i == last_q)) |=> !busy);

    p_hold_last_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(last_q));

    p_busy_only_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(busy) |-> $past(tick));

endmodule

bind state_uart_reporter state_uart_reporter_chk #(
    .STATE_W(STATE_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .state_i(state_i),
    .tx     (tx_o),
    .busy   (busy_o),
    .tick   (baud_tick),
    .last_q (last_rep)
);

// File: tb/state_uart_reporter_tb.sv
`timescale 1ns/1ps
module state_uart_reporter_tb;

    localparam int BIT = 16;
    localparam int FRAME_CYC = 11 * BIT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] state_i = 5'd0;
    logic       tx_o;
    logic       busy_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    state_uart_reporter #(
        .CLKS_PER_BIT(BIT),
        .STATE_W(5),
        .DATA_W(8)
    ) u_dut (
        .clk    (clk),
        .rst    (rst),
        .state_i(state_i),
        .tx_o   (tx_o),
        .busy_o (busy_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [4:0] s);
        return {3'b000, s};
    endfunction

    // waits for a start bit and decodes one frame at mid-bit
    task automatic recv(output bit got, output logic [7:0] d, output logic st,
                        output logic p, output logic sp, output int len);
        got = 0; d = '0; st = 1'b1; p = 1'b0; sp = 1'b0; len = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (!tx_o) begin
                got = 1;
                break;
            end
        end
        if (!got) return;
        for (int t = 0; t < 4 * FRAME_CYC; t++) begin
            if (t > 0) @(negedge clk);
            if (!busy_o) break;
            len++;
            if (t % BIT == BIT / 2) begin
                if (t / BIT == 0) st = tx_o;
                else if (t / BIT <= 8) d[t / BIT - 1] = tx_o;
                else if (t / BIT == 9) p = tx_o;
                else if (t / BIT == 10) sp = tx_o;
            end
        end
    endtask

    task automatic expect_frame(input string req, input logic [4:0] s);
        bit got; logic [7:0] d; logic st, p, sp; int len;
        recv(got, d, st, p, sp, len);
        check(got, req, "frame started", got, 1);
        if (!got) return;
        check(st == 1'b0, "R3", "start bit", st, 0);
        check(d == exp_byte(s), req, "data byte", d, exp_byte(s));
        check(p == ^exp_byte(s), "R3", "parity bit", p, ^exp_byte(s));
        check(sp == 1'b1, "R3", "stop bit", sp, 1);
        check(len == FRAME_CYC, "R4/R5", "busy length", len, FRAME_CYC);
    endtask

    task automatic expect_quiet(input string req, input int cyc);
        int bad = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (!tx_o || busy_o) bad++;
        end
        check(bad == 0, req, "line quiet (cycles active)", bad, 0);
    endtask

    task automatic t_reset_idle();
        int bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!tx_o || busy_o) bad++;
        end
        check(bad == 0, "R1", "idle during reset", bad, 0);
        rst = 1'b0;
        expect_quiet("R2", 200); // state 0 equals reset value
    endtask

    task automatic t_single(input logic [4:0] s);
        @(negedge clk);
        state_i = s;
        expect_frame("R2/R3", s);
        expect_quiet("R1", 3 * BIT);
    endtask

    task automatic t_coalesce(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c);
        @(negedge clk);
        state_i = a;
        fork
            expect_frame("R6", a);
            begin
                repeat (60) @(negedge clk);
                state_i = b;
                repeat (40) @(negedge clk);
                state_i = c;
            end
        join
        expect_frame("R6", c);
        expect_quiet("R6", 300);
    endtask

    task automatic t_revert(input logic [4:0] x, input logic [4:0] y);
        @(negedge clk);
        state_i = x;
        fork
            expect_frame("R7", x);
            begin
                repeat (50) @(negedge clk);
                state_i = y;
                repeat (50) @(negedge clk);
                state_i = x;
            end
        join
        expect_quiet("R7", 300);
    endtask

    task automatic t_mid_reset(input logic [4:0] v);
        bit seen = 0;
        @(negedge clk);
        state_i = v;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (!tx_o) begin
                seen = 1;
                break;
            end
        end
        check(seen, "R8", "frame started before reset", seen, 1);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(tx_o == 1'b1, "R8", "tx after reset edge", tx_o, 1);
        check(busy_o == 1'b0, "R8", "busy after reset edge", busy_o, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_frame("R8", v);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_single(5'h1F);
        t_single(5'h15);
        t_single(5'h0A);
        t_single(5'h01);
        expect_quiet("R2", 300);
        t_coalesce(5'h03, 5'h0C, 5'h11);
        t_revert(5'h06, 5'h19);
        t_mid_reset(5'h0E);
        t_single(5'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule